// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block runs the host side of a three-wire serial link to a 16-bit successive-approximation converter. The converter has no busy indicator, and its data-input pin is tied high. One output line does two jobs: its rising edge starts a conversion, and its low level selects the converter for readout. When the controller is idle and sees a start request, or has continuous mode enabled, it raises that line. It keeps the line high for a fixed worst-case conversion time so that the converter never signals busy. It then lowers the line, waits a setup interval so the first data bit can settle, and generates 16 serial clock pulses. The controller captures a bit on each falling clock edge. The converter only moves to its next bit a hold time after that edge, so the bit captured is the one already on the line.

The result leaves the block on a valid/ready stream. `res_valid_o` rises in the cycle that follows the 16th falling edge. It stays high with the word held steady until a cycle in which `res_ready_i` is high. A consumer that keeps ready high therefore sees a one-cycle pulse. While a result is still waiting, no new conversion starts. Back-pressure therefore slows the sampling rate and never loses a word. After each readout the controller waits a minimum acquisition time before the next conversion can begin. Every timing interval is a parameter counted in system-clock cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cnv_o`, `sck_o`, `res_valid_o` and `busy_o` are all low.
- R2: When the block is idle with no result pending and `start_i` or `auto_i` is sampled high, `cnv_o` rises on that clock edge and stays high for exactly CONV_CYC cycles.
- R3: `sck_o` is low whenever `cnv_o` is high. The first rising edge of `sck_o` comes exactly SETUP_CYC cycles after `cnv_o` falls.
- R4: Each conversion produces exactly 16 `sck_o` pulses. Each pulse is high for SCK_HI_CYC cycles, and the gap between pulses is SCK_LO_CYC cycles. `sck_o` idles low.
- R5: The controller captures one bit on each clock edge that drops `sck_o`, namely the value on `sdo_i` just before that edge. The first captured bit becomes bit 15 of `res_data_o` and the last becomes bit 0.
- R6: `res_valid_o` rises in the first cycle in which `sck_o` is low after its 16th pulse.
- R7: After the 16th falling edge of `sck_o`, `cnv_o` stays low for at least ACQ_CYC+1 cycles. If a start is already pending, it stays low for exactly ACQ_CYC+1 cycles.
- R8: `busy_o` is high from the rise of `cnv_o` until the acquisition wait has ended and no result is pending. A start request sampled while `busy_o` is high starts no conversion.
- R9: While `auto_i` is held high, conversions follow one another with no start request. Each one returns the word the converter presented.
- R10: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` and `res_data_o` hold their values and no conversion starts. `res_valid_o` drops in the cycle after a clock edge at which `res_ready_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion (level, sampled while idle) |
| auto_i | input | 1 | Continuous mode: start a new conversion each time the block is idle |
| cnv_o | output | 1 | Conversion start and chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter, idles low |
| sdo_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Conversion, readout, acquisition wait or undelivered result in progress |
| res_valid_o | output | 1 | Result word valid |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | DATA_W | Converted word, MSB first on the wire |

## Verification
The checker assumes two things about the inputs. First, the converter moves `sdo_i` to its next bit only after the falling edge of `sck_o`, not in the same clock cycle. Second, `res_ready_i` changes only between clock edges. The stand-in converter in the bench meets both. It updates its output one nanosecond after each `sck_o` falling edge or `cnv_o` falling edge. All inputs, including ready and the start requests, are driven on falling system-clock edges. The bench varies `res_ready_i` only in the back-pressure test, and the hold property covers that case.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_CONV,
    RD_SETUP,
    RD_SCKH,
    RD_SCKL,
    RD_ACQ
  } rd_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_tmr.sv
module adc_rd_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         last_o,
  output logic [W-1:0] word_o
);

  localparam int CW = $clog2(W);

  logic [W-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= word_o[W-2:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(W - 1));
  assign word_o = {sh_q, bit_i};

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W     = 16,
  parameter int CONV_CYC   = 71,
  parameter int SETUP_CYC  = 2,
  parameter int SCK_HI_CYC = 2,
  parameter int SCK_LO_CYC = 2,
  parameter int ACQ_CYC    = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              auto_i,
  output logic              cnv_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic              busy_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o
);
  import adc_rd_pkg::*;

  localparam int T_MAX = max_of(max_of(CONV_CYC, SETUP_CYC),
                                max_of(max_of(SCK_HI_CYC, SCK_LO_CYC), ACQ_CYC));
  localparam int TW = $clog2(T_MAX + 1);

  rd_state_t         state_q, state_d;
  logic              cnv_q, cnv_d, sck_q, sck_d;
  logic              tmr_ld, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              sh_en, sh_clr, sh_last, fin;
  logic [DATA_W-1:0] sh_word;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  adc_rd_tmr #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  adc_rd_shift #(.W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sh_clr),
    .en_i   (sh_en),
    .bit_i  (sdo_i),
    .last_o (sh_last),
    .word_o (sh_word)
  );

  always_comb begin
    state_d = state_q;
    cnv_d   = cnv_q;
    sck_d   = sck_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    sh_en   = 1'b0;
    sh_clr  = 1'b0;
    fin     = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if ((start_i || auto_i) && !valid_q) begin
          state_d = RD_CONV;
          cnv_d   = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = TW'(CONV_CYC - 1);
          sh_clr  = 1'b1;
        end
      end
      RD_CONV: begin
        if (tmr_zero) begin
          state_d = RD_SETUP;
          cnv_d   = 1'b0;
          tmr_ld  = 1'b1;
          tmr_val = TW'(SETUP_CYC - 1);
        end
      end
      RD_SETUP: begin
        if (tmr_zero) begin
          state_d = RD_SCKH;
          sck_d   = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = TW'(SCK_HI_CYC - 1);
        end
      end
      RD_SCKH: begin
        if (tmr_zero) begin
          sck_d  = 1'b0;
          sh_en  = 1'b1;
          tmr_ld = 1'b1;
          if (sh_last) begin
            fin     = 1'b1;
            state_d = RD_ACQ;
            tmr_val = TW'(ACQ_CYC - 1);
          end else begin
            state_d = RD_SCKL;
            tmr_val = TW'(SCK_LO_CYC - 1);
          end
        end
      end
      RD_SCKL: begin
        if (tmr_zero) begin
          state_d = RD_SCKH;
          sck_d   = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = TW'(SCK_HI_CYC - 1);
        end
      end
      RD_ACQ: begin
        if (tmr_zero) begin
          state_d = RD_IDLE;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      cnv_q   <= 1'b0;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnv_q   <= cnv_d;
      sck_q   <= sck_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (fin) begin
      valid_q <= 1'b1;
      data_q  <= sh_word;
    end else if (res_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign cnv_o       = cnv_q;
  assign sck_o       = sck_q;
  assign busy_o      = (state_q != RD_IDLE) || valid_q;
  assign res_valid_o = valid_q;
  assign res_data_o  = data_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 71,
  parameter int ACQ_CYC  = 29
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnv_o,
  input logic              sck_o,
  input logic              busy_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [DATA_W-1:0] res_data_o
);

  localparam int unsigned GAP_MIN = ACQ_CYC + 1;

  int unsigned hi_cnt, fall_cnt, low_cnt;
  logic        sck_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= 0;
      fall_cnt <= 0;
      low_cnt  <= GAP_MIN;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_o;
      hi_cnt   <= cnv_o ? hi_cnt + 1 : 0;
      if (cnv_o) fall_cnt <= 0;
      else if (sck_prev && !sck_o) fall_cnt <= fall_cnt + 1;
      if (sck_o) low_cnt <= 0;
      else if (low_cnt < GAP_MIN) low_cnt <= low_cnt + 1;
    end
  end

  assert_cnv_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> hi_cnt == CONV_CYC);

  assert_sck_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> !sck_o);

  assert_sixteen_pulses_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> ($fell(sck_o) && fall_cnt == DATA_W - 1));

  assert_acq_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> low_cnt >= GAP_MIN);

  assert_idle_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $past(!busy_o));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DATA_W   (DATA_W),
  .CONV_CYC (CONV_CYC),
  .ACQ_CYC  (ACQ_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnv_o       (cnv_o),
  .sck_o       (sck_o),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;

  localparam int DW    = 16;
  localparam int CONV  = 12;
  localparam int SETUP = 2;
  localparam int HI    = 2;
  localparam int LO    = 3;
  localparam int ACQ   = 5;
  localparam int NV    = 8;
  localparam logic [DW-1:0] VEC [NV] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                                         16'hA5A5, 16'h5A5A, 16'h7FFE, 16'h1234};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, auto_en = 1'b0, ready = 1'b1;
  logic cnv, sck, busy, valid;
  logic sdo = 1'b0;
  logic [DW-1:0] data;

  always #2 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(DW), .CONV_CYC(CONV), .SETUP_CYC(SETUP), .SCK_HI_CYC(HI),
                .SCK_LO_CYC(LO), .ACQ_CYC(ACQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .auto_i(auto_en),
    .cnv_o(cnv), .sck_o(sck), .sdo_i(sdo), .busy_o(busy),
    .res_valid_o(valid), .res_ready_i(ready), .res_data_o(data));

  // stand-in converter: MSB on convert fall, next bit a hold time after each clock fall
  logic [DW-1:0] adc_word = '0, adc_sh = '0;
  always @(posedge cnv) begin adc_sh = adc_word; sdo = 1'b0; end
  always @(negedge cnv) begin #1; sdo = adc_sh[DW-1]; end
  always @(negedge sck) begin #1; adc_sh = adc_sh << 1; sdo = adc_sh[DW-1]; end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // timing monitor (R2, R3, R4, R6, R7)
  int cnv_cnt, set_cnt, hi_cnt, lo_cnt, gap_cnt, falls, rises;
  bit p_cnv, p_sck, setup_on, gap_on, seen, gap_exact;
  always @(negedge clk) begin
    if (!rst_n) begin
      cnv_cnt = 0; set_cnt = 0; hi_cnt = 0; lo_cnt = 0; gap_cnt = 0; falls = 0; rises = 0;
      p_cnv = 0; p_sck = 0; setup_on = 0; gap_on = 0; seen = 0;
    end else begin
      if (cnv && !p_cnv) begin
        rises++;
        if (seen) chk(falls == 16, "R4 pulse count", falls, 16);
        if (gap_on) begin
          if (gap_exact) chk(gap_cnt == ACQ + 1, "R7 gap exact", gap_cnt, ACQ + 1);
          else chk(gap_cnt >= ACQ + 1, "R7 gap min", gap_cnt, ACQ + 1);
        end
        gap_on = 0; falls = 0; cnv_cnt = 0; seen = 1;
      end
      if (cnv) begin
        cnv_cnt++;
        if (sck) chk(0, "R3 sck while cnv", 1, 0);
      end
      if (!cnv && p_cnv) begin
        chk(cnv_cnt == CONV, "R2 cnv width", cnv_cnt, CONV);
        setup_on = 1; set_cnt = 0;
      end
      if (setup_on && !cnv && !sck) set_cnt++;
      if (sck && !p_sck) begin
        if (setup_on) chk(set_cnt == SETUP, "R3 setup", set_cnt, SETUP);
        else chk(lo_cnt == LO, "R4 low width", lo_cnt, LO);
        setup_on = 0; hi_cnt = 0;
      end
      if (sck) hi_cnt++;
      if (!sck && p_sck) begin
        chk(hi_cnt == HI, "R4 high width", hi_cnt, HI);
        falls++; lo_cnt = 0;
        if (falls == 16) begin
          chk(valid == 1'b1, "R6 valid at last fall", valid, 1);
          gap_on = 1; gap_cnt = 0;
        end
      end
      if (!sck) lo_cnt++;
      if (gap_on && !cnv) gap_cnt++;
      p_cnv = cnv; p_sck = sck;
    end
  end

  task automatic wait_valid();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (valid) return;
    end
    chk(0, "R5 result timeout", 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    chk(0, "R8 idle timeout", 1, 0);
  endtask

  task automatic one_conv(input logic [DW-1:0] w);
    adc_word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid();
    chk(data == w, "R5 data", data, w);
    @(negedge clk);
    chk(valid == 1'b0, "R6 one-cycle pulse", valid, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cnv, sck, valid, busy} == 4'b0, "R1 reset state", {cnv, sck, valid, busy}, 0);

    // vector table walk (R2..R6)
    for (int v = 0; v < NV; v++) begin
      one_conv(VEC[v]);
      wait_idle();
    end

    // R8: start held during a conversion launches only one
    r0 = rises;
    adc_word = 16'h3C3C;
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during conversion", busy, 1);
    repeat (20) @(negedge clk);
    start = 1'b0;
    wait_valid();
    chk(data == 16'h3C3C, "R8 data", data, 16'h3C3C);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(rises - r0 == 1, "R8 one conversion", rises - r0, 1);
    chk(busy == 1'b0, "R8 busy released", busy, 0);

    // R9 / R7: continuous mode, back-to-back conversions
    adc_word = 16'hC001;
    auto_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      logic [DW-1:0] exp_w;
      exp_w = adc_word;
      wait_valid();
      chk(data == exp_w, "R9 auto data", data, exp_w);
      adc_word = exp_w + 16'h1111;
      gap_exact = 1'b1;
      @(negedge clk);
    end
    auto_en = 1'b0;
    wait_idle();
    gap_exact = 1'b0;

    // R10: back-pressure holds result and blocks starts
    ready = 1'b0;
    adc_word = 16'hBEEF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid();
    r0 = rises;
    start = 1'b1;
    repeat (20) @(negedge clk);
    chk(valid == 1'b1, "R10 valid held", valid, 1);
    chk(data == 16'hBEEF, "R10 data held", data, 16'hBEEF);
    chk(rises == r0, "R10 no start while pending", rises - r0, 0);
    start = 1'b0;
    ready = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R10 valid drops after ready", valid, 0);
    repeat (10) @(negedge clk);
    chk(rises == r0, "R10 start ignored", rises - r0, 0);

    summary();
    $finish;
  end

endmodule